// File: doc/BRIEF.md
# Stream Write Stop-Command Sequencer

This block governs the closing phase of an open-ended stream write to a memory card. Software starts a stream by giving the total byte count. The transmit path then reports each byte that leaves the controller with a one-cycle strobe, and the sequencer counts the bytes still to be sent. A fixed number of bytes before the end, it raises an interrupt that tells the host to prepare the stop transmission command. The stop command has to go out on the command line while the last `OVERLAP_BYTES` data bytes (six by default) are still being sent. The sequencer issues a one-cycle start pulse to the command serializer at exactly that point. If the host is late, the sequencer holds back the data path until the command has been loaded.

The host may gate the controller clock, for example while it rewrites the command registers. While the clock enable is low the sequencer keeps its state. The host's load handshake is still recorded during that time. After the last byte the sequencer raises a data-done interrupt. It then watches the card's busy line through a synchronizer. When the card has pulled the line low and released it again, the sequencer raises a programming-done interrupt. The interrupts stay set until the host issues a clear, and the clear also returns the sequencer to idle.

Top module: `stream_stop_seq`

## Requirements
- R1: After reset, `irq_stop_ready`, `irq_data_done`, `irq_prog_done`, `cmd_start` and `tx_stall` are all low.
- R2: `irq_stop_ready` goes high one cycle after the count of bytes still to send falls to `OVERLAP_BYTES + SETUP_LAT` (10 by default). It then stays high until a host clear.
- R3: `cmd_start` is a pulse one cycle wide. It is issued only after the host has loaded the stop command, and only when exactly `OVERLAP_BYTES` bytes remain to be sent.
- R4: When `OVERLAP_BYTES` bytes remain and the stop command has not been launched, `tx_stall` is high. Byte strobes given while `tx_stall` is high are not counted.
- R5: `irq_data_done` goes high one cycle after the final byte is accepted. It then stays high until a host clear.
- R6: `irq_prog_done` goes high only after `irq_data_done`. The synchronized `card_busy_n` must first be seen low and then high again, with low meaning the card is busy.
- R7: While `run_en` is low, byte strobes are ignored, the state and interrupts hold, and no `cmd_start` is issued. A `cmd_loaded` pulse given while stop-ready is pending is still recorded.
- R8: `host_clear` returns the sequencer to idle and drives all interrupts, `cmd_start` and `tx_stall` low. In idle, byte strobes have no effect.
- R9: If the total byte count is already at or below `OVERLAP_BYTES + SETUP_LAT`, `irq_stop_ready` goes high in the cycle after the stream is loaded, before any byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Controller clock enable; low freezes the sequencer |
| start | input | 1 | Begins a stream and loads `total_bytes` (taken in idle only) |
| total_bytes | input | CNT_W | Number of bytes in the stream |
| byte_sent | input | 1 | One transmit byte left the controller this cycle |
| tx_stall | output | 1 | Data path must hold the next byte |
| cmd_loaded | input | 1 | Host has written the stop command registers |
| card_busy_n | input | 1 | Card busy line, low while the card programs |
| host_clear | input | 1 | Clears interrupts and returns to idle |
| cmd_start | output | 1 | One-cycle start pulse for the stop command serializer |
| irq_stop_ready | output | 1 | Stop command may be loaded |
| irq_data_done | output | 1 | Final data byte has been sent |
| irq_prog_done | output | 1 | Card finished programming |

## Verification
Two things can happen in the same cycle: the stop command launch, and a byte strobe reaching the point where six bytes remain. The bench provokes this in two ways. In one stream the host loads the command early, with the clock stopped. In the other it loads late, and the bench keeps strobing bytes while `tx_stall` is high. A scoreboard records how many bytes the bench has had accepted at each interrupt edge and at each `cmd_start` pulse, and judges those counts. So a strobe that slipped through during the stall, or during the stopped clock, shows up as a count that is off by one.

// File: rtl/sss_pkg.sv
package sss_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STREAM,
      ST_STOP_READY,
      ST_OVERLAP,
      ST_DATA_DONE,
      ST_WAIT_BUSY,
      ST_FINISHED
   } seq_state_e;
endpackage

// File: rtl/sss_byte_ctr.sv
// Countdown of bytes still to be sent in the current stream.
module sss_byte_ctr #(
   parameter int CNT_W    = 16,
   parameter int READY_AT = 10,
   parameter int OVERLAP  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             at_ready,
   output logic             at_overlap,
   output logic             is_zero
);
   localparam logic [CNT_W-1:0] READY_V   = CNT_W'(READY_AT);
   localparam logic [CNT_W-1:0] OVERLAP_V = CNT_W'(OVERLAP);

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rem_q <= '0;
      else if (load)                rem_q <= load_val;
      else if (dec && rem_q != '0)  rem_q <= rem_q - 1'b1;
   end

   assign at_ready   = (rem_q <= READY_V);
   assign at_overlap = (rem_q <= OVERLAP_V);
   assign is_zero    = (rem_q == '0);
endmodule

// File: rtl/sss_busy_sync.sv
// Synchronizer for the card busy line; STAGES = 0 passes it straight through.
module sss_busy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_n_in,
   output logic busy_n_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign busy_n_out = busy_n_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else begin
               sh_q[0] <= busy_n_in;
               for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign busy_n_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sss_ctrl.sv
// Phase controller: stream, stop launch, data end, card programming.
module sss_ctrl
   import sss_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic start,
   input  logic host_clear,
   input  logic cmd_loaded,
   input  logic byte_sent,
   input  logic at_ready,
   input  logic at_overlap,
   input  logic is_zero,
   input  logic busy_n_s,
   output logic ctr_load,
   output logic ctr_dec,
   output logic tx_stall,
   output logic cmd_start,
   output logic irq_stop_ready,
   output logic irq_data_done,
   output logic irq_prog_done
);
   seq_state_e st_q, st_d;
   logic       loaded_q;
   logic       go_cmd;
   logic       accepting;

   always_comb begin
      st_d   = st_q;
      go_cmd = 1'b0;
      unique case (st_q)
         ST_IDLE:       if (start)      st_d = ST_STREAM;
         ST_STREAM:     if (at_ready)   st_d = ST_STOP_READY;
         ST_STOP_READY: if (at_overlap && loaded_q) begin
                           st_d   = ST_OVERLAP;
                           go_cmd = 1'b1;
                        end
         ST_OVERLAP:    if (is_zero)    st_d = ST_DATA_DONE;
         ST_DATA_DONE:  if (!busy_n_s)  st_d = ST_WAIT_BUSY;
         ST_WAIT_BUSY:  if (busy_n_s)   st_d = ST_FINISHED;
         ST_FINISHED:   st_d = ST_FINISHED;
         default:       st_d = ST_IDLE;
      endcase
   end

   // Bytes are taken only where the countdown cannot jump past a boundary.
   assign accepting = (st_q == ST_STREAM     && !at_ready)   ||
                      (st_q == ST_STOP_READY && !at_overlap) ||
                      (st_q == ST_OVERLAP);
   assign tx_stall  = (st_q == ST_STOP_READY && at_overlap) ||
                      (st_q == ST_STREAM     && at_ready);
   assign ctr_load  = (st_q == ST_IDLE) && start && run_en && !host_clear;
   assign ctr_dec   = run_en && byte_sent && accepting && !is_zero && !host_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q           <= ST_IDLE;
         loaded_q       <= 1'b0;
         cmd_start      <= 1'b0;
         irq_stop_ready <= 1'b0;
         irq_data_done  <= 1'b0;
         irq_prog_done  <= 1'b0;
      end else if (host_clear) begin
         st_q           <= ST_IDLE;
         loaded_q       <= 1'b0;
         cmd_start      <= 1'b0;
         irq_stop_ready <= 1'b0;
         irq_data_done  <= 1'b0;
         irq_prog_done  <= 1'b0;
      end else begin
         cmd_start <= run_en && go_cmd;
         if (st_q == ST_IDLE)                            loaded_q <= 1'b0;
         else if (st_q == ST_STOP_READY && cmd_loaded)   loaded_q <= 1'b1;
         if (run_en) begin
            st_q <= st_d;
            if (st_d == ST_STOP_READY && st_q != ST_STOP_READY) irq_stop_ready <= 1'b1;
            if (st_d == ST_DATA_DONE  && st_q != ST_DATA_DONE)  irq_data_done  <= 1'b1;
            if (st_d == ST_FINISHED   && st_q != ST_FINISHED)   irq_prog_done  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/stream_stop_seq.sv
// Top: ties the countdown, busy synchronizer and phase controller together.
module stream_stop_seq #(
   parameter int CNT_W         = 16,
   parameter int OVERLAP_BYTES = 6,
   parameter int SETUP_LAT     = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             start,
   input  logic [CNT_W-1:0] total_bytes,
   input  logic             byte_sent,
   output logic             tx_stall,
   input  logic             cmd_loaded,
   input  logic             card_busy_n,
   input  logic             host_clear,
   output logic             cmd_start,
   output logic             irq_stop_ready,
   output logic             irq_data_done,
   output logic             irq_prog_done
);
   localparam int READY_AT = OVERLAP_BYTES + SETUP_LAT;

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("stream_stop_seq: CNT_W must lie in 4..32");
      end
      if (OVERLAP_BYTES < 1) begin : g_bad_overlap
         $error("stream_stop_seq: OVERLAP_BYTES must be at least 1");
      end
      if (SETUP_LAT < 0 || READY_AT >= (2 ** CNT_W)) begin : g_bad_lat
         $error("stream_stop_seq: ready threshold does not fit the counter");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("stream_stop_seq: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic ctr_load, ctr_dec;
   logic at_ready, at_overlap, is_zero;
   logic busy_n_s;

   sss_byte_ctr #(
      .CNT_W   (CNT_W),
      .READY_AT(READY_AT),
      .OVERLAP (OVERLAP_BYTES)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ctr_load),
      .load_val  (total_bytes),
      .dec       (ctr_dec),
      .at_ready  (at_ready),
      .at_overlap(at_overlap),
      .is_zero   (is_zero)
   );

   sss_busy_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_n_in (card_busy_n),
      .busy_n_out(busy_n_s)
   );

   sss_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_en        (run_en),
      .start         (start),
      .host_clear    (host_clear),
      .cmd_loaded    (cmd_loaded),
      .byte_sent     (byte_sent),
      .at_ready      (at_ready),
      .at_overlap    (at_overlap),
      .is_zero       (is_zero),
      .busy_n_s      (busy_n_s),
      .ctr_load      (ctr_load),
      .ctr_dec       (ctr_dec),
      .tx_stall      (tx_stall),
      .cmd_start     (cmd_start),
      .irq_stop_ready(irq_stop_ready),
      .irq_data_done (irq_data_done),
      .irq_prog_done (irq_prog_done)
   );
endmodule

// File: rtl/stream_stop_seq_chk.sv
// Protocol checker attached to every stream_stop_seq instance.
module stream_stop_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic host_clear,
   input logic tx_stall,
   input logic cmd_start,
   input logic irq_stop_ready,
   input logic irq_data_done,
   input logic irq_prog_done
);
   // R3: the launch pulse never lasts two cycles
   p_cmd_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   // R4: the data path is never held once the data has finished
   p_no_stall_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_data_done |-> !tx_stall);

   // R5: data end is only reported after stop-ready
   p_data_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_data_done |-> irq_stop_ready);

   // R6: programming end is only reported after data end
   p_prog_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_prog_done |-> irq_data_done);

   // R7: a stopped clock freezes the interrupts and launches nothing
   p_frozen_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !host_clear) |=>
         ($stable({irq_stop_ready, irq_data_done, irq_prog_done}) && !cmd_start));

   // R8: a clear leaves every output low
   p_clear_all_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_clear |=> !(irq_stop_ready || irq_data_done || irq_prog_done ||
                       cmd_start || tx_stall));
endmodule

bind stream_stop_seq stream_stop_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .run_en        (run_en),
   .host_clear    (host_clear),
   .tx_stall      (tx_stall),
   .cmd_start     (cmd_start),
   .irq_stop_ready(irq_stop_ready),
   .irq_data_done (irq_data_done),
   .irq_prog_done (irq_prog_done)
);

// File: tb/stream_stop_seq_bench.sv
`timescale 1ns/1ps
module stream_stop_seq_bench;
   localparam int CNT_W = 16;
   localparam int EV_READY = 0;
   localparam int EV_CMD   = 1;
   localparam int EV_DONE  = 2;
   localparam int EV_PROG  = 3;

   typedef struct {
      int code;
      int cnt;
   } ev_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             run_en = 1'b1;
   logic             start = 1'b0;
   logic [CNT_W-1:0] total_bytes = '0;
   logic             byte_sent = 1'b0;
   logic             tx_stall;
   logic             cmd_loaded = 1'b0;
   logic             card_busy_n = 1'b1;
   logic             host_clear = 1'b0;
   logic             cmd_start;
   logic             irq_stop_ready, irq_data_done, irq_prog_done;

   int  n_chk = 0;
   int  n_fail = 0;
   int  bytes_acc = 0;
   ev_t exp_q[$];
   logic pv_rdy = 1'b0, pv_cmd = 1'b0, pv_done = 1'b0, pv_prog = 1'b0;

   always #2.5 clk = ~clk;

   stream_stop_seq u_stream_stop_seq (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
      .total_bytes(total_bytes), .byte_sent(byte_sent), .tx_stall(tx_stall),
      .cmd_loaded(cmd_loaded), .card_busy_n(card_busy_n), .host_clear(host_clear),
      .cmd_start(cmd_start), .irq_stop_ready(irq_stop_ready),
      .irq_data_done(irq_data_done), .irq_prog_done(irq_prog_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic string req_of(input int code);
      case (code)
         EV_READY: return "R2 stop-ready byte count";
         EV_CMD:   return "R3 launch byte count";
         EV_DONE:  return "R5 data-done byte count";
         default:  return "R6 prog-done byte count";
      endcase
   endfunction

   function automatic logic sig(input int code);
      case (code)
         EV_READY: return irq_stop_ready;
         EV_CMD:   return cmd_start;
         EV_DONE:  return irq_data_done;
         default:  return irq_prog_done;
      endcase
   endfunction

   task automatic expect_ev(input int code, input int cnt);
      ev_t e;
      e.code = code;
      e.cnt  = cnt;
      exp_q.push_back(e);
   endtask

   task automatic got(input int code);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, {req_of(code), " (unexpected event)"}, code, -1);
      end else begin
         e = exp_q.pop_front();
         chk(e.code == code, {req_of(e.code), " (event order)"}, code, e.code);
         chk(e.cnt == bytes_acc, req_of(e.code), bytes_acc, e.cnt);
      end
   endtask

   // Monitor: settled outputs just after each edge, compared against the queue.
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (irq_stop_ready && !pv_rdy)  got(EV_READY);
         if (cmd_start && !pv_cmd)       got(EV_CMD);
         if (cmd_start && pv_cmd)        chk(1'b0, "R3 pulse width", 2, 1);
         if (irq_data_done && !pv_done)  got(EV_DONE);
         if (irq_prog_done && !pv_prog)  got(EV_PROG);
      end
      pv_rdy  = irq_stop_ready;
      pv_cmd  = cmd_start;
      pv_done = irq_data_done;
      pv_prog = irq_prog_done;
   end

   task automatic start_stream(input int total);
      @(negedge clk);
      bytes_acc   = 0;
      total_bytes = CNT_W'(total);
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_byte();
      @(negedge clk);
      while (tx_stall) @(negedge clk);
      byte_sent = 1'b1;
      bytes_acc++;
      @(negedge clk);
      byte_sent = 1'b0;
   endtask

   task automatic send_n(input int n);
      for (int i = 0; i < n; i++) send_byte();
   endtask

   task automatic raw_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         byte_sent = 1'b1;
         @(negedge clk);
         byte_sent = 1'b0;
      end
   endtask

   task automatic load_cmd();
      @(negedge clk);
      cmd_loaded = 1'b1;
      @(negedge clk);
      cmd_loaded = 1'b0;
   endtask

   task automatic wait_sig(input int code, input string req);
      int k;
      k = 0;
      while (!sig(code) && k < 300) begin
         @(negedge clk);
         k++;
      end
      chk(sig(code) == 1'b1, req, int'(sig(code)), 1);
   endtask

   task automatic clear_and_check(input string req);
      @(negedge clk);
      host_clear = 1'b1;
      @(negedge clk);
      host_clear = 1'b0;
      chk({irq_stop_ready, irq_data_done, irq_prog_done, cmd_start, tx_stall} == 5'b0,
          req, int'({irq_stop_ready, irq_data_done, irq_prog_done, cmd_start, tx_stall}), 0);
   endtask

   task automatic prog_phase();
      wait_sig(EV_DONE, "R5 data-done raised");
      repeat (3) @(negedge clk);
      chk(irq_prog_done == 1'b0, "R6 no prog-done before busy", int'(irq_prog_done), 0);
      card_busy_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(irq_prog_done == 1'b0, "R6 no prog-done while busy", int'(irq_prog_done), 0);
      card_busy_n = 1'b1;
      wait_sig(EV_PROG, "R6 prog-done raised");
      chk(irq_data_done == 1'b1, "R5 data-done sticky", int'(irq_data_done), 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({irq_stop_ready, irq_data_done, irq_prog_done, cmd_start, tx_stall} == 5'b0,
          "R1 reset outputs", int'({irq_stop_ready, irq_data_done, irq_prog_done, cmd_start, tx_stall}), 0);

      // Stream A: 20 bytes, stop command loaded early while the clock is stopped.
      expect_ev(EV_READY, 10);
      expect_ev(EV_CMD, 14);
      expect_ev(EV_DONE, 20);
      expect_ev(EV_PROG, 20);
      start_stream(20);
      send_n(10);
      wait_sig(EV_READY, "R2 stop-ready raised");
      @(negedge clk);
      run_en = 1'b0;
      raw_pulse(2);                 // R7: ignored while stopped
      load_cmd();                   // R7: still recorded
      chk(irq_data_done == 1'b0 && cmd_start == 1'b0, "R7 frozen while stopped",
          int'({irq_data_done, cmd_start}), 0);
      @(negedge clk);
      run_en = 1'b1;
      send_n(10);
      prog_phase();
      clear_and_check("R8 clear after stream A");

      // Stream B: 16 bytes, host late, strobes during the stall.
      expect_ev(EV_READY, 6);
      expect_ev(EV_CMD, 10);
      expect_ev(EV_DONE, 16);
      expect_ev(EV_PROG, 16);
      start_stream(16);
      send_n(10);
      @(negedge clk);
      chk(tx_stall == 1'b1, "R4 stall with six left", int'(tx_stall), 1);
      raw_pulse(2);                 // R4: not counted
      repeat (3) @(negedge clk);
      chk(tx_stall == 1'b1 && cmd_start == 1'b0, "R4 stall held until load",
          int'({tx_stall, cmd_start}), 2);
      load_cmd();
      send_n(6);
      prog_phase();
      clear_and_check("R8 clear after stream B");

      // Stream C cut short by a clear, then strobes in idle.
      start_stream(30);
      send_n(3);
      clear_and_check("R8 clear mid-stream");
      raw_pulse(3);
      chk({irq_stop_ready, irq_data_done, cmd_start, tx_stall} == 4'b0, "R8 idle ignores strobes",
          int'({irq_stop_ready, irq_data_done, cmd_start, tx_stall}), 0);

      // Stream D: 8 bytes, below the ready threshold from the start.
      expect_ev(EV_READY, 0);
      expect_ev(EV_CMD, 2);
      expect_ev(EV_DONE, 8);
      expect_ev(EV_PROG, 8);
      start_stream(8);
      @(negedge clk);
      chk(irq_stop_ready == 1'b1, "R9 immediate stop-ready", int'(irq_stop_ready), 1);
      load_cmd();
      send_n(8);
      prog_phase();
      clear_and_check("R8 clear after stream D");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule